// File: doc/BRIEF.md
# PCI Configuration Access Router

This block takes host configuration-space requests and turns each one into a single targeted register access on an internal configuration bus. Requests arrive through one valid/ready request channel that carries a port code selecting one of three entry points: a 32-bit address latch, a data window that uses the latch, or a memory-mapped configuration window decoded from a physical address. Each accepted request is resolved into a bus number, a device/function index and a register offset, together with a byte count of 1, 2 or 4.

Requests for bus 0 are issued on a local strobe port, which addresses one of 256 device/function slots. Requests for any other bus are issued on a bridge forwarding port with the full address, data and size. Reads that are disabled, malformed or aimed at an empty slot return all ones, and reads beyond the 256-byte local space return zero. A read produces one response pulse in the cycle after it is accepted, and the request channel stalls during that cycle, so at most one read is in flight.

Top module: `cfg_access_router`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, and the address latch holds 0 (a 4-byte read of port code 0 returns 0x00000000).
- R2: Port code 0 is the address latch. It is written and read only with size 4. A write of any other size leaves it unchanged, and a read of any other size returns all ones masked to the requested size.
- R3: A data-window access (port code 1) while latch bit 31 is 0 is ignored. A read returns all ones masked to the size, and a write raises neither strobe.
- R4: A data-window access while latch bits [1:0] are nonzero is ignored in the same way as R3.
- R5: A data-window access takes bus = latch[23:16], devfn = latch[15:8], and register = {latch[7:2], req_addr[1:0]}.
- R6: Port code 2 decodes req_addr only inside the 256 MB window at 0xD0000000. Bus is addr[27:20], devfn is addr[19:12], and register is addr[11:0]. An address outside the window, or port code 3, is ignored as in R3.
- R7: A resolved request with a nonzero bus raises brg_valid, carrying bus, devfn, 12-bit register, size and data, and never raises loc_valid. Its read data is brg_rdata masked to the size.
- R8: A bus-0 request whose register plus size exceeds 256 is refused. A read returns 0, and a write raises no strobe.
- R9: A bus-0 read to a slot with loc_present = 0 returns all ones masked to the size. Otherwise it returns loc_rdata masked to the size.
- R10: Sizes other than 1, 2 and 4 raise no strobe, and a read returns 0xFFFFFFFF. Strobed write data and returned read data are zero-extended to the size (1 byte = 0xFF mask, 2 bytes = 0xFFFF mask).
- R11: A read accepted in cycle N gives rsp_valid = 1 with its data in cycle N+1, and req_ready = 0 in that cycle. A write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 2 | 0 latch, 1 data window, 2 memory window, 3 reserved |
| req_addr | input | 32 | Window byte address or physical address |
| req_size | input | 3 | Byte count (1, 2 or 4) |
| req_wdata | input | 32 | Write data, low bytes used |
| rsp_valid | output | 1 | Read response pulse |
| rsp_rdata | output | 32 | Read response data |
| loc_valid | output | 1 | Local slot access strobe |
| loc_write | output | 1 | Local access is a write |
| loc_devfn | output | 8 | Local device/function index |
| loc_reg | output | 8 | Local register offset |
| loc_size | output | 3 | Local access byte count |
| loc_wdata | output | 32 | Local write data, zero-extended |
| loc_present | input | 1 | Addressed local slot is populated |
| loc_rdata | input | 32 | Local read data |
| brg_valid | output | 1 | Bridge forwarding strobe |
| brg_write | output | 1 | Bridge access is a write |
| brg_bus | output | 8 | Target bus number |
| brg_devfn | output | 8 | Target device/function |
| brg_reg | output | 12 | Target register offset |
| brg_size | output | 3 | Bridge access byte count |
| brg_wdata | output | 32 | Bridge write data, zero-extended |
| brg_rdata | input | 32 | Bridge read data |

## Verification
Almost all state sits in the address latch and the one-cycle response register. A corrupted latch shows up on the next 4-byte latch readback, and in the devfn or register fields of the next data-window strobe. A routing fault appears in the same cycle as the request, as a strobe on the wrong port or with wrong fields. A response fault shows one cycle later as a missing, extra or mis-masked rsp_valid pulse. The sweeps cover every devfn on both decoded paths, all lanes and sizes, and the 256-byte boundary.

// File: rtl/cfgr_pkg.sv
// Shared types for the configuration access router.
// Assumes bus and device/function indices are 8 bits each.
package cfgr_pkg;

    localparam int BUS_W   = 8;
    localparam int DEVFN_W = 8;

    typedef enum logic [1:0] {
        PORT_LATCH  = 2'd0,
        PORT_WINDOW = 2'd1,
        PORT_MMIO   = 2'd2,
        PORT_RSVD   = 2'd3
    } port_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_LATCH,
        TGT_LOCAL,
        TGT_REFUSE,
        TGT_BRIDGE
    } tgt_e;

    // Legal byte counts are 1, 2 and 4.
    function automatic logic size_ok(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

    // Zero-extension mask for a byte count. Illegal counts keep all bits.
    function automatic logic [31:0] size_mask(input logic [2:0] sz);
        case (sz)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfgr_decode.sv
// Request decoder: resolves a request into target class, bus, devfn and register.
// Assumes the memory window width leaves 8 bus bits, 8 devfn bits and REG_W register bits.
module cfgr_decode
    import cfgr_pkg::*;
#(
    parameter logic [31:0] MMIO_BASE  = 32'hD000_0000,
    parameter int          MMIO_AW    = 28,
    parameter int          LOCAL_SPAN = 256,
    localparam int         REG_W      = MMIO_AW - BUS_W - DEVFN_W
) (
    input  logic [1:0]         port,
    input  logic [31:0]        addr,
    input  logic [2:0]         size,
    input  logic [31:0]        latch_q,
    output tgt_e               tgt,
    output logic [BUS_W-1:0]   bus,
    output logic [DEVFN_W-1:0] devfn,
    output logic [REG_W-1:0]   regno
);

    localparam int DEVFN_MSB = REG_W + DEVFN_W - 1;
    localparam int BUS_MSB   = MMIO_AW - 1;

    logic            resolved;
    logic [REG_W:0]  end_off;

    // Field extraction per entry point.
    always_comb begin
        resolved = 1'b0;
        bus      = '0;
        devfn    = '0;
        regno    = '0;
        case (port_e'(port))
            PORT_WINDOW: begin
                if (latch_q[31] && (latch_q[1:0] == 2'b00)) begin
                    resolved = 1'b1;
                    bus      = latch_q[23:16];
                    devfn    = latch_q[15:8];
                    regno    = REG_W'({latch_q[7:2], addr[1:0]});
                end
            end
            PORT_MMIO: begin
                if (addr[31:MMIO_AW] == MMIO_BASE[31:MMIO_AW]) begin
                    resolved = 1'b1;
                    bus      = addr[BUS_MSB -: BUS_W];
                    devfn    = addr[DEVFN_MSB -: DEVFN_W];
                    regno    = addr[REG_W-1:0];
                end
            end
            default: ;
        endcase
    end

    assign end_off = {1'b0, regno} + (REG_W+1)'(size);

    // Target classification: latch, bridge, local, refused or ignored.
    always_comb begin
        tgt = TGT_NONE;
        if (port_e'(port) == PORT_LATCH) begin
            if (size == 3'd4) tgt = TGT_LATCH;
        end else if (resolved && size_ok(size)) begin
            if (bus != '0)                            tgt = TGT_BRIDGE;
            else if (end_off > (REG_W+1)'(LOCAL_SPAN)) tgt = TGT_REFUSE;
            else                                       tgt = TGT_LOCAL;
        end
    end

endmodule

// File: rtl/cfgr_addr_latch.sv
// Legacy address latch: a 32-bit register loaded by full-width writes.
// Assumes the caller qualifies the write enable.
module cfgr_addr_latch (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] q
);

    // Hold or load the latch.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wr_data;
    end

endmodule

// File: rtl/cfgr_respond.sv
// Read data selection and one-cycle response register.
// Assumes capture is asserted only for accepted reads.
module cfgr_respond
    import cfgr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        capture,
    input  tgt_e        tgt,
    input  logic [2:0]  size,
    input  logic [31:0] latch_q,
    input  logic        loc_present,
    input  logic [31:0] loc_rdata,
    input  logic [31:0] brg_rdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata
);

    logic [31:0] raw;

    // Source selection by target class.
    always_comb begin
        case (tgt)
            TGT_LATCH:  raw = latch_q;
            TGT_LOCAL:  raw = loc_present ? loc_rdata : 32'hFFFF_FFFF;
            TGT_REFUSE: raw = 32'h0000_0000;
            TGT_BRIDGE: raw = brg_rdata;
            default:    raw = 32'hFFFF_FFFF;
        endcase
    end

    // Register the response one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_rdata <= raw & size_mask(size);
        end
    end

endmodule

// File: rtl/cfg_access_router.sv
// Configuration access router top level: accepts one request per cycle when ready,
// routes it to the latch, a local slot or the bridge port, and returns read data one
// cycle later. Assumes responders answer combinationally in the strobe cycle.
module cfg_access_router
    import cfgr_pkg::*;
#(
    parameter logic [31:0] MMIO_BASE  = 32'hD000_0000,
    parameter int          MMIO_AW    = 28,
    parameter int          LOCAL_SPAN = 256,
    localparam int         REG_W      = MMIO_AW - BUS_W - DEVFN_W,
    localparam int         LREG_W     = $clog2(LOCAL_SPAN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [1:0]          req_port,
    input  logic [31:0]         req_addr,
    input  logic [2:0]          req_size,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic [31:0]         rsp_rdata,
    output logic                loc_valid,
    output logic                loc_write,
    output logic [DEVFN_W-1:0]  loc_devfn,
    output logic [LREG_W-1:0]   loc_reg,
    output logic [2:0]          loc_size,
    output logic [31:0]         loc_wdata,
    input  logic                loc_present,
    input  logic [31:0]         loc_rdata,
    output logic                brg_valid,
    output logic                brg_write,
    output logic [BUS_W-1:0]    brg_bus,
    output logic [DEVFN_W-1:0]  brg_devfn,
    output logic [REG_W-1:0]    brg_reg,
    output logic [2:0]          brg_size,
    output logic [31:0]         brg_wdata,
    input  logic [31:0]         brg_rdata
);

    tgt_e               tgt;
    logic [BUS_W-1:0]   bus;
    logic [DEVFN_W-1:0] devfn;
    logic [REG_W-1:0]   regno;
    logic [31:0]        latch_q;
    logic [31:0]        wdata_ext;
    logic               fire;

    // One read in flight: stall while its response is presented.
    assign req_ready = !rsp_valid;
    assign fire      = req_valid && req_ready;
    assign wdata_ext = req_wdata & size_mask(req_size);

    cfgr_decode #(
        .MMIO_BASE  (MMIO_BASE),
        .MMIO_AW    (MMIO_AW),
        .LOCAL_SPAN (LOCAL_SPAN)
    ) decode_i (
        .port    (req_port),
        .addr    (req_addr),
        .size    (req_size),
        .latch_q (latch_q),
        .tgt     (tgt),
        .bus     (bus),
        .devfn   (devfn),
        .regno   (regno)
    );

    cfgr_addr_latch latch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fire && req_write && (tgt == TGT_LATCH)),
        .wr_data (req_wdata),
        .q       (latch_q)
    );

    cfgr_respond respond_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (fire && !req_write),
        .tgt         (tgt),
        .size        (req_size),
        .latch_q     (latch_q),
        .loc_present (loc_present),
        .loc_rdata   (loc_rdata),
        .brg_rdata   (brg_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );

    // Local slot strobe and fields.
    assign loc_valid = fire && (tgt == TGT_LOCAL);
    assign loc_write = req_write;
    assign loc_devfn = devfn;
    assign loc_reg   = regno[LREG_W-1:0];
    assign loc_size  = req_size;
    assign loc_wdata = wdata_ext;

    // Bridge forwarding strobe and fields.
    assign brg_valid = fire && (tgt == TGT_BRIDGE);
    assign brg_write = req_write;
    assign brg_bus   = bus;
    assign brg_devfn = devfn;
    assign brg_reg   = regno;
    assign brg_size  = req_size;
    assign brg_wdata = wdata_ext;

    // R7: a request never reaches both target ports.
    p_single_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loc_valid, brg_valid}));

    // R7: the bridge port only sees nonzero bus numbers.
    p_bridge_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        brg_valid |-> (brg_bus != '0));

    // R8: local accesses stay inside the local space.
    p_local_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid |-> (({2'b00, loc_reg} + (LREG_W+2)'(loc_size)) <= (LREG_W+2)'(LOCAL_SPAN)));

    // R10: only legal sizes reach a target port.
    p_legal_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid || brg_valid) |-> size_ok(req_size));

    // R11: an accepted read is answered in the next cycle.
    p_read_answered_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid);

    // R11: every response comes from an accepted read.
    p_rsp_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && !req_write));

    // R11: no acceptance while a response is presented.
    p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

endmodule

// File: tb/cfg_access_router_tb_top.sv
// Self-checking bench: sweeps devfn, lanes and sizes on both decoded paths.
module cfg_access_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_port = 2'd0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        loc_valid, loc_write, loc_present;
    logic [7:0]  loc_devfn, loc_reg;
    logic [2:0]  loc_size;
    logic [31:0] loc_wdata, loc_rdata;
    logic        brg_valid, brg_write;
    logic [7:0]  brg_bus, brg_devfn;
    logic [11:0] brg_reg;
    logic [2:0]  brg_size;
    logic [31:0] brg_wdata, brg_rdata;

    int vectors = 0;
    int misses  = 0;
    int loc_hits = 0;
    int brg_hits = 0;
    logic [7:0]  c_ldevfn, c_lreg;
    logic [2:0]  c_lsize;
    logic [31:0] c_lwdata;
    logic        c_lwrite;
    logic [7:0]  c_bbus, c_bdevfn;
    logic [11:0] c_breg;
    logic [31:0] c_bwdata;

    always #2 clk = ~clk;

    // Responder models.
    function automatic logic slot_present(input logic [7:0] d);
        return (d % 3) != 2;
    endfunction
    function automatic logic [31:0] slot_data(input logic [7:0] d, input logic [7:0] r);
        return {d, ~d, r, r ^ 8'hA5};
    endfunction
    function automatic logic [31:0] mask_of(input int sz);
        return (sz == 1) ? 32'hFF : (sz == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction
    function automatic logic [31:0] exp_local(input int d, input int r, input int sz);
        if (r + sz > 256) return 32'h0;
        if (!slot_present(8'(d))) return mask_of(sz);
        return slot_data(8'(d), 8'(r)) & mask_of(sz);
    endfunction

    assign loc_present = slot_present(loc_devfn);
    assign loc_rdata   = loc_present ? slot_data(loc_devfn, loc_reg) : 32'h1234_5678;
    assign brg_rdata   = {brg_bus, brg_devfn, 4'hC, brg_reg};

    cfg_access_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_port(req_port), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .loc_valid(loc_valid), .loc_write(loc_write), .loc_devfn(loc_devfn),
        .loc_reg(loc_reg), .loc_size(loc_size), .loc_wdata(loc_wdata),
        .loc_present(loc_present), .loc_rdata(loc_rdata),
        .brg_valid(brg_valid), .brg_write(brg_write), .brg_bus(brg_bus),
        .brg_devfn(brg_devfn), .brg_reg(brg_reg), .brg_size(brg_size),
        .brg_wdata(brg_wdata), .brg_rdata(brg_rdata)
    );

    // Strobe monitor at the ports.
    always @(posedge clk) begin
        if (loc_valid) begin
            loc_hits++;
            c_ldevfn = loc_devfn; c_lreg = loc_reg; c_lsize = loc_size;
            c_lwdata = loc_wdata; c_lwrite = loc_write;
        end
        if (brg_valid) begin
            brg_hits++;
            c_bbus = brg_bus; c_bdevfn = brg_devfn; c_breg = brg_reg; c_bwdata = brg_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    // One request; returns response state sampled after the accepting edge.
    task automatic access(input logic [1:0] p, input logic w, input logic [31:0] a,
                          input logic [2:0] sz, input logic [31:0] wd,
                          output logic [31:0] rd, output logic got, output logic rdy);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_port = p; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata; got = rsp_valid; rdy = req_ready;
    endtask

    task automatic rd(input logic [1:0] p, input logic [31:0] a, input logic [2:0] sz,
                      output logic [31:0] d);
        logic g, r;
        access(p, 1'b0, a, sz, 32'h0, d, g, r);
    endtask

    task automatic wr(input logic [1:0] p, input logic [31:0] a, input logic [2:0] sz,
                      input logic [31:0] wd);
        logic [31:0] d;
        logic g, r;
        access(p, 1'b1, a, sz, wd, d, g, r);
    endtask

    initial begin
        #(4 * 190000);
        vectors++; misses++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [31:0] d;
        logic g, r;
        int h;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk("R1 ready", {31'b0, req_ready}, 32'h1);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
        rd(2'd0, 32'h0, 3'd4, d);
        chk("R1 latch", d, 32'h0);

        // R2: latch full-width only.
        wr(2'd0, 32'h0, 3'd4, 32'h8012_3404);
        rd(2'd0, 32'h0, 3'd4, d);
        chk("R2 readback", d, 32'h8012_3404);
        wr(2'd0, 32'h0, 3'd2, 32'h0000_FFFF);
        rd(2'd0, 32'h0, 3'd4, d);
        chk("R2 subword write ignored", d, 32'h8012_3404);
        rd(2'd0, 32'h0, 3'd1, d);
        chk("R2 subword read", d, 32'h0000_00FF);

        // R3: enable bit clear.
        wr(2'd0, 32'h0, 3'd4, 32'h0000_0100);
        rd(2'd1, 32'h0, 3'd4, d); chk("R3 read4", d, 32'hFFFF_FFFF);
        rd(2'd1, 32'h1, 3'd2, d); chk("R3 read2", d, 32'h0000_FFFF);
        h = loc_hits;
        wr(2'd1, 32'h0, 3'd4, 32'hDEAD_BEEF);
        chk("R3 write no strobe", 32'(loc_hits), 32'(h));

        // R4: misaligned latch.
        wr(2'd0, 32'h0, 3'd4, 32'h8000_0101);
        rd(2'd1, 32'h0, 3'd4, d); chk("R4 low bits 01", d, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0, 3'd4, 32'h8000_0102);
        rd(2'd1, 32'h0, 3'd1, d); chk("R4 low bits 10", d, 32'h0000_00FF);
        h = loc_hits;
        wr(2'd1, 32'h0, 3'd1, 32'h55);
        chk("R4 write no strobe", 32'(loc_hits), 32'(h));

        // R5, R8, R9: data-window sweep over every devfn, lane and size.
        for (int dv = 0; dv < 256; dv++) begin
            wr(2'd0, 32'h0, 3'd4, 32'h8000_0000 | (dv << 8) | ((dv & 63) << 2));
            for (int ln = 0; ln < 4; ln++) begin
                for (int si = 0; si < 3; si++) begin
                    int sz;
                    int rg;
                    sz = (si == 0) ? 1 : (si == 1) ? 2 : 4;
                    rg = ((dv & 63) << 2) | ln;
                    rd(2'd1, 32'(ln), 3'(sz), d);
                    chk("R5 R8 R9 window read", d, exp_local(dv, rg, sz));
                end
            end
        end

        // R5: local strobe fields on a window write (R10 masking of write data).
        wr(2'd0, 32'h0, 3'd4, 32'h8000_2110);
        h = loc_hits;
        wr(2'd1, 32'h2, 3'd2, 32'h1234_ABCD);
        chk("R5 strobe count", 32'(loc_hits), 32'(h + 1));
        chk("R5 devfn", {24'b0, c_ldevfn}, 32'h21);
        chk("R5 reg", {24'b0, c_lreg}, 32'h12);
        chk("R10 wdata masked", c_lwdata, 32'h0000_ABCD);
        chk("R5 write flag", {31'b0, c_lwrite}, 32'h1);

        // R6, R8, R9: memory-window sweep on bus 0.
        for (int dv = 0; dv < 256; dv++) begin
            int rg;
            rg = (dv % 4 == 0) ? (((dv & 15) << 8) | dv) : dv;
            for (int si = 0; si < 3; si++) begin
                int sz;
                sz = (si == 0) ? 1 : (si == 1) ? 2 : 4;
                rd(2'd2, 32'hD000_0000 | (dv << 12) | rg, 3'(sz), d);
                chk("R6 R8 R9 mmio read", d, exp_local(dv, rg, sz));
            end
        end
        rd(2'd2, 32'hE000_0000, 3'd4, d);  chk("R6 above window", d, 32'hFFFF_FFFF);
        rd(2'd2, 32'hCFFF_FFFC, 3'd2, d);  chk("R6 below window", d, 32'h0000_FFFF);
        rd(2'd3, 32'hD000_0000, 3'd4, d);  chk("R6 reserved port", d, 32'hFFFF_FFFF);

        // R8: refused writes raise no strobe.
        h = loc_hits;
        wr(2'd2, 32'hD000_3100, 3'd1, 32'h1);
        wr(2'd2, 32'hD000_30FE, 3'd4, 32'h1);
        chk("R8 refused write", 32'(loc_hits), 32'(h));

        // R7: bridge forwarding.
        foreach (brg_bus[i]) begin end
        for (int bi = 0; bi < 3; bi++) begin
            int b;
            b = (bi == 0) ? 1 : (bi == 1) ? 8'h80 : 8'hFF;
            h = loc_hits;
            rd(2'd2, 32'hD000_0000 | (b << 20) | (8'h5A << 12) | 12'hFFF, 3'd4, d);
            chk("R7 mmio bridge read", d, {8'(b), 8'h5A, 4'hC, 12'hFFF});
            chk("R7 no local strobe", 32'(loc_hits), 32'(h));
        end
        wr(2'd0, 32'h0, 3'd4, 32'h8005_0F20);
        rd(2'd1, 32'h3, 3'd1, d);
        chk("R7 window bridge read", d, 32'h0000_0023 & 32'hFF);
        h = brg_hits;
        wr(2'd2, 32'hD030_7345, 3'd4, 32'hCAFE_F00D);
        chk("R7 bridge count", 32'(brg_hits), 32'(h + 1));
        chk("R7 bridge bus", {24'b0, c_bbus}, 32'h03);
        chk("R7 bridge devfn", {24'b0, c_bdevfn}, 32'h07);
        chk("R7 bridge reg", {20'b0, c_breg}, 32'h345);
        chk("R7 bridge wdata", c_bwdata, 32'hCAFE_F00D);

        // R10: illegal sizes.
        h = loc_hits + brg_hits;
        rd(2'd2, 32'hD000_0000, 3'd0, d); chk("R10 size0", d, 32'hFFFF_FFFF);
        rd(2'd2, 32'hD000_0000, 3'd3, d); chk("R10 size3", d, 32'hFFFF_FFFF);
        rd(2'd2, 32'hD010_0000, 3'd5, d); chk("R10 size5", d, 32'hFFFF_FFFF);
        chk("R10 no strobe", 32'(loc_hits + brg_hits), 32'(h));
        wr(2'd2, 32'hD000_1010, 3'd1, 32'hAABB_CCDD);
        chk("R10 byte wdata", c_lwdata, 32'h0000_00DD);

        // R11: response timing.
        access(2'd2, 1'b0, 32'hD000_1000, 3'd4, 32'h0, d, g, r);
        chk("R11 read rsp", {31'b0, g}, 32'h1);
        chk("R11 stall", {31'b0, r}, 32'h0);
        access(2'd2, 1'b1, 32'hD000_1000, 3'd4, 32'h0, d, g, r);
        chk("R11 write no rsp", {31'b0, g}, 32'h0);

        summary();
    end

endmodule